// File: doc/BRIEF.md
# Iterative In-Place Fixed-Point Radix-2 FFT Core

This block computes a complex discrete Fourier transform of `N_PTS` points, where `N_PTS` is a power of two of at least four. Samples stream in through a valid/ready handshake in natural order. Real and imaginary parts are stored in two separate word arrays, so one access moves a whole complex value. After the last sample is accepted, a single controller runs log2(N) radix-2 stages of N/2 butterflies each. It walks them as a stage loop, a group loop and a loop over butterflies inside a group. Every butterfly writes its results back to the addresses it read, and it always takes exactly three clock cycles.

Twiddle factors come from a constant table of N/2 entries that is computed at elaboration. The arithmetic is 16-bit two's complement with Q1.14 twiddles. There is no scaling between stages, so large inputs wrap. When the last butterfly is written, the core raises `done` and presents the results on a second valid/ready handshake in storage order, which is bit-reversed frequency order. A cycle counter reports how long the computation took. Once the final word has been read, the core is ready to load the next frame.

Top module: `fft_core`

## Requirements
- R1: In the cycle after synchronous reset is released, `in_ready` is 1 and both `out_valid` and `done` are 0.
- R2: A sample is taken on each rising edge where `in_valid` and `in_ready` are both 1. The k-th sample taken (counting from 0) is input index k. Cycles with `in_valid` at 0 take nothing. In the cycle after the N-th sample is taken, `in_ready` is 0.
- R3: The transform is defined as follows. For stage s = 0..L−1 (L = log2 N), let h = N/2^(s+1). Block g holds the indices g·2h .. g·2h+2h−1. In block g, index i pairs with j = i+h, and the pair uses twiddle W^e with e = the (L−1)-bit reversal of g. Here W^e has real part round(16384·cos(2πe/N)) and imaginary part −round(16384·sin(2πe/N)), with halves rounded away from zero. The butterfly forms t = W^e·X[j], and each of the four 32-bit products is arithmetically shifted right by 14 before the products are combined. It then sets X[j] = X[i] − t and X[i] = X[i] + t.
- R4: Output word p (0-based) is the final value at index p, which is frequency bin number rev_L(p). For example, an input alternating +A, −A gives N·A at word 1 and 0 everywhere else.
- R5: `done` rises exactly 3·L·N/2 clock cycles after the edge that takes the last sample (96 cycles for N = 16).
- R6: While `done` is 1, `busy_cycles` equals 3·L·N/2.
- R7: `out_valid` equals `done`. While `out_valid` is 1 and `out_ready` is 0, the next cycle shows the same `out_re`/`out_im` with `out_valid` still 1. Each edge with `out_valid` and `out_ready` both 1 advances to the next word.
- R8: `out_last` is 1 exactly on word N−1. In the cycle after that word is taken, `done` is 0 and `in_ready` is 1.
- R9: `in_valid` and the input data have no effect while `in_ready` is 0, that is, during computation and readout. `in_ready` and `out_valid` are never 1 together.
- R10: Every sum and difference is kept to 16 bits with two's-complement wraparound and no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core is accepting samples |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_re | output | 16 | Output real part, signed |
| out_im | output | 16 | Output imaginary part, signed |
| out_last | output | 1 | Current output word is the final one |
| done | output | 1 | Transform complete, results readable |
| busy_cycles | output | CNT_W | Cycles spent computing the last frame |

## Verification
Wrong internal state surfaces in different ways.
- A wrong pair address, twiddle index or product shift corrupts output words of the very frame being computed, so a bit-exact comparison of every word catches it on the first frame that excites the affected bins.
- A miscounted stage or butterfly counter moves the rise of `done` away from 3·L·N/2 cycles. The same error shows in `busy_cycles` within that frame.
- A slip in the load or readout pointers shows up in the following ways:
  - as shifted words;
  - as a misplaced `out_last`;
  - as `in_ready` failing to return right after the final word is taken.

// File: rtl/fft_pkg.sv
package fft_pkg;

    localparam int DATA_W = 16;
    localparam int TWID_W = 16;
    localparam int FRAC_W = 14;
    localparam int PROD_W = DATA_W + TWID_W;
    localparam real TWO_PI = 6.283185307179586;

    typedef struct packed {
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [TWID_W-1:0] re;
        logic signed [TWID_W-1:0] im;
    } twid_t;

    typedef enum logic [1:0] {ST_LOAD, ST_RUN, ST_OUT} state_e;
    typedef enum logic [1:0] {PH_READ, PH_MUL, PH_WRITE} phase_e;

    // round half away from zero
    function automatic int round_q(real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return $rtoi(v - 0.5);
    endfunction

    function automatic logic signed [TWID_W-1:0] tw_re_q(int e, int n);
        return TWID_W'(round_q($cos(TWO_PI * real'(e) / real'(n)) * real'(1 << FRAC_W)));
    endfunction

    function automatic logic signed [TWID_W-1:0] tw_im_q(int e, int n);
        return TWID_W'(-round_q($sin(TWO_PI * real'(e) / real'(n)) * real'(1 << FRAC_W)));
    endfunction

    // reverse the low nb bits of v
    function automatic int unsigned bit_rev(int unsigned v, int unsigned nb);
        int unsigned r;
        r = 0;
        for (int q = 0; q < 32; q++) begin
            if (q < nb) r = (r << 1) | ((v >> q) & 32'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fft_bank.sv
module fft_bank
    import fft_pkg::*;
#(
    parameter int N_PTS = 16,
    localparam int AW = $clog2(N_PTS)
) (
    input  logic                     clk,
    input  logic                     we_a,
    input  logic [AW-1:0]            addr_a,
    input  logic signed [DATA_W-1:0] din_a,
    output logic signed [DATA_W-1:0] dout_a,
    input  logic                     we_b,
    input  logic [AW-1:0]            addr_b,
    input  logic signed [DATA_W-1:0] din_b,
    output logic signed [DATA_W-1:0] dout_b
);

    logic signed [DATA_W-1:0] mem [N_PTS];

    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= din_a;
        if (we_b) mem[addr_b] <= din_b;
    end

    assign dout_a = mem[addr_a];
    assign dout_b = mem[addr_b];

endmodule

// File: rtl/fft_twrom.sv
module fft_twrom
    import fft_pkg::*;
#(
    parameter int N_PTS = 16,
    localparam int IW = $clog2(N_PTS) - 1
) (
    input  logic [IW-1:0] tw_idx,
    output twid_t         tw_o
);

    twid_t tab [N_PTS/2];

    for (genvar e = 0; e < N_PTS/2; e++) begin : g_entry
        localparam logic signed [TWID_W-1:0] CR = tw_re_q(e, N_PTS);
        localparam logic signed [TWID_W-1:0] CI = tw_im_q(e, N_PTS);
        assign tab[e].re = CR;
        assign tab[e].im = CI;
    end

    assign tw_o = tab[tw_idx];

endmodule

// File: rtl/fft_agen.sv
module fft_agen
    import fft_pkg::*;
#(
    parameter int N_PTS = 16,
    localparam int LOG2N = $clog2(N_PTS),
    localparam int AW = LOG2N,
    localparam int SW = $clog2(LOG2N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] idx_i,
    output logic [AW-1:0] idx_j,
    output logic [AW-2:0] tw_idx,
    output logic          last
);

    logic [SW-1:0] stage_q;
    logic [AW-2:0] b_q;
    logic          stage_end;

    assign stage_end = (b_q == '1);
    assign last      = stage_end && (stage_q == SW'(LOG2N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            b_q     <= '0;
        end else if (step) begin
            if (stage_end) begin
                b_q     <= '0;
                stage_q <= last ? '0 : stage_q + SW'(1);
            end else begin
                b_q <= b_q + (AW-1)'(1);
            end
        end
    end

    // stage -> half span, butterfly count -> group and offset
    always_comb begin
        int unsigned s, h, g, k, base;
        s      = 32'(stage_q);
        h      = 32'(N_PTS) >> (s + 1);
        g      = 32'(b_q) >> (32'(LOG2N) - 1 - s);
        k      = 32'(b_q) & (h - 1);
        base   = g * 2 * h + k;
        idx_i  = AW'(base);
        idx_j  = AW'(base + h);
        tw_idx = (AW-1)'(bit_rev(g, 32'(LOG2N) - 1));
    end

    // R5: the final butterfly returns the walk to its start
    p_walk_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (step && last) |=> (stage_q == '0 && b_q == '0));

    // R3: partner index always lies above the upper-wing index
    p_pair_order_r3: assert property (@(posedge clk) disable iff (rst)
        step |-> (idx_j > idx_i));

endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
    import fft_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_op,
    input  logic  ld_mul,
    input  cplx_t a_in,
    input  cplx_t b_in,
    input  twid_t w_in,
    output cplx_t sum_o,
    output cplx_t dif_o
);

    cplx_t a_q, b_q, t_q, t_c;
    twid_t w_q;
    logic signed [PROD_W-1:0] p_rr, p_ii, p_ri, p_ir;

    always_comb begin
        p_rr   = b_q.re * w_q.re;
        p_ii   = b_q.im * w_q.im;
        p_ri   = b_q.im * w_q.re;
        p_ir   = b_q.re * w_q.im;
        t_c.re = DATA_W'((p_rr >>> FRAC_W) - (p_ii >>> FRAC_W));
        t_c.im = DATA_W'((p_ri >>> FRAC_W) + (p_ir >>> FRAC_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            w_q <= '0;
            t_q <= '0;
        end else begin
            if (ld_op) begin
                a_q <= a_in;
                b_q <= b_in;
                w_q <= w_in;
            end
            if (ld_mul) t_q <= t_c;
        end
    end

    assign sum_o.re = a_q.re + t_q.re;
    assign sum_o.im = a_q.im + t_q.im;
    assign dif_o.re = a_q.re - t_q.re;
    assign dif_o.im = a_q.im - t_q.im;

endmodule

// File: rtl/fft_core.sv
module fft_core
    import fft_pkg::*;
#(
    parameter int N_PTS = 16,
    localparam int LOG2N = $clog2(N_PTS),
    localparam int AW = LOG2N,
    localparam int RUN_CYC = 3 * LOG2N * (N_PTS / 2),
    localparam int CNT_W = $clog2(RUN_CYC + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im,
    output logic                     out_last,
    output logic                     done,
    output logic [CNT_W-1:0]         busy_cycles
);

    state_e           state_q;
    phase_e           phase_q;
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] lat_q;

    logic          take_in, give_out, bf_write, agen_last;
    logic [AW-1:0] idx_i, idx_j, addr_a;
    logic [AW-2:0] tw_idx;
    twid_t         tw;
    cplx_t         rd_a, rd_b, bf_sum, bf_dif, wr_a;

    assign take_in  = in_valid && (state_q == ST_LOAD);
    assign give_out = out_ready && (state_q == ST_OUT);
    assign bf_write = (state_q == ST_RUN) && (phase_q == PH_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_LOAD;
            phase_q  <= PH_READ;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            lat_q    <= '0;
        end else begin
            case (state_q)
                ST_LOAD: if (take_in) begin
                    wr_ptr_q <= wr_ptr_q + AW'(1);
                    if (wr_ptr_q == AW'(N_PTS - 1)) begin
                        state_q <= ST_RUN;
                        phase_q <= PH_READ;
                        lat_q   <= '0;
                    end
                end
                ST_RUN: begin
                    lat_q <= lat_q + CNT_W'(1);
                    case (phase_q)
                        PH_READ: phase_q <= PH_MUL;
                        PH_MUL:  phase_q <= PH_WRITE;
                        default: begin
                            phase_q <= PH_READ;
                            if (agen_last) begin
                                state_q  <= ST_OUT;
                                rd_ptr_q <= '0;
                            end
                        end
                    endcase
                end
                default: if (give_out) begin
                    rd_ptr_q <= rd_ptr_q + AW'(1);
                    if (rd_ptr_q == AW'(N_PTS - 1)) state_q <= ST_LOAD;
                end
            endcase
        end
    end

    fft_agen #(.N_PTS(N_PTS)) u_agen (
        .clk(clk), .rst(rst), .step(bf_write),
        .idx_i(idx_i), .idx_j(idx_j), .tw_idx(tw_idx), .last(agen_last)
    );

    fft_twrom #(.N_PTS(N_PTS)) u_rom (.tw_idx(tw_idx), .tw_o(tw));

    fft_bfly u_bfly (
        .clk(clk), .rst(rst),
        .ld_op ((state_q == ST_RUN) && (phase_q == PH_READ)),
        .ld_mul((state_q == ST_RUN) && (phase_q == PH_MUL)),
        .a_in(rd_a), .b_in(rd_b), .w_in(tw),
        .sum_o(bf_sum), .dif_o(bf_dif)
    );

    always_comb begin
        case (state_q)
            ST_LOAD: addr_a = wr_ptr_q;
            ST_OUT:  addr_a = rd_ptr_q;
            default: addr_a = idx_i;
        endcase
        if (state_q == ST_LOAD) begin
            wr_a.re = in_re;
            wr_a.im = in_im;
        end else begin
            wr_a = bf_sum;
        end
    end

    fft_bank #(.N_PTS(N_PTS)) u_bank_re (
        .clk(clk),
        .we_a(take_in || bf_write), .addr_a(addr_a), .din_a(wr_a.re), .dout_a(rd_a.re),
        .we_b(bf_write), .addr_b(idx_j), .din_b(bf_dif.re), .dout_b(rd_b.re)
    );

    fft_bank #(.N_PTS(N_PTS)) u_bank_im (
        .clk(clk),
        .we_a(take_in || bf_write), .addr_a(addr_a), .din_a(wr_a.im), .dout_a(rd_a.im),
        .we_b(bf_write), .addr_b(idx_j), .din_b(bf_dif.im), .dout_b(rd_b.im)
    );

    assign in_ready    = (state_q == ST_LOAD);
    assign out_valid   = (state_q == ST_OUT);
    assign done        = (state_q == ST_OUT);
    assign out_re      = rd_a.re;
    assign out_im      = rd_a.im;
    assign out_last    = (state_q == ST_OUT) && (rd_ptr_q == AW'(N_PTS - 1));
    assign busy_cycles = lat_q;

    // R1
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid && !done));

    // R2
    p_load_close_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && wr_ptr_q == AW'(N_PTS - 1)) |=> !in_ready);

    // R5, R6
    p_done_count_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (busy_cycles == CNT_W'(RUN_CYC)));

    // R7
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

    // R8
    p_last_return_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !done));

    // R9
    p_side_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

endmodule

// File: tb/sim_fft_core.sv
module sim_fft_core;
    localparam int N = 16;
    localparam int L = 4;
    localparam int RUNC = 3 * L * (N / 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic in_ready, out_valid, out_last, done;
    logic signed [15:0] out_re, out_im;
    logic [6:0] busy_cycles;

    int errors = 0, checks = 0, cyc = 0;
    int xr [N], xi [N], er [N], ei [N];
    int seed = 12345;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fft_core #(.N_PTS(N)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im), .out_last(out_last), .done(done),
        .busy_cycles(busy_cycles)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int w16(int v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    function automatic int rnd(real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return $rtoi(v - 0.5);
    endfunction

    function automatic int rev(int v, int nb);
        int r = 0;
        for (int q = 0; q < nb; q++) r = (r << 1) | ((v >> q) & 1);
        return r;
    endfunction

    function automatic int nextr(int lim);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) % lim);
    endfunction

    // arithmetic of R3 and R10 applied to xr/xi
    task automatic model();
        for (int n = 0; n < N; n++) begin er[n] = xr[n]; ei[n] = xi[n]; end
        for (int s = 0; s < L; s++) begin
            int h = N >> (s + 1);
            for (int g = 0; g < N / (2 * h); g++) begin
                int e = rev(g, L - 1);
                int wr = rnd(16384.0 * $cos(6.283185307179586 * e / N));
                int wi = -rnd(16384.0 * $sin(6.283185307179586 * e / N));
                for (int k = 0; k < h; k++) begin
                    int i = g * 2 * h + k;
                    int j = i + h;
                    int tr = w16(((wr * er[j]) >>> 14) - ((wi * ei[j]) >>> 14));
                    int ti = w16(((wr * ei[j]) >>> 14) + ((wi * er[j]) >>> 14));
                    int ar = er[i], ai = ei[i];
                    er[j] = w16(ar - tr); ei[j] = w16(ai - ti);
                    er[i] = w16(ar + tr); ei[i] = w16(ai + ti);
                end
            end
        end
    endtask

    task automatic do_frame(int pat);
        int n, acc, idx, waited;
        bit rdy, stalled, junk_ok;
        int pre, pim;
        string tag;
        for (int k = 0; k < N; k++) begin
            case (pat)
                0: begin xr[k] = (k == 0) ? 100 : 0; xi[k] = 0; end
                1: begin xr[k] = (k % 2 == 0) ? 300 : -300; xi[k] = 0; end
                2: begin xr[k] = 50; xi[k] = -20; end
                3: begin xr[k] = nextr(2000) - 1000; xi[k] = nextr(2000) - 1000; end
                4: begin xr[k] = (k % 3 == 0) ? 30000 : 29000 - 1000 * k; xi[k] = -32768 + 37 * k; end
                default: begin xr[k] = nextr(60000) - 30000; xi[k] = nextr(60000) - 30000; end
            endcase
        end
        tag = (pat >= 4) ? "R10" : "R3";
        model();
        // load with gaps (R2)
        n = 0;
        while (n < N) begin
            if (pat % 2 == 1 && (cyc % 3 == 0)) in_valid = 1'b0;
            else begin in_valid = 1'b1; in_re = 16'(xr[n]); in_im = 16'(xi[n]); end
            rdy = in_ready;
            @(posedge clk); #1;
            if (in_valid && rdy) n++;
        end
        acc = cyc;
        chk(in_ready == 1'b0, "R2 ready drops after N samples", int'(in_ready), 0);
        // compute with junk on the input side (R9)
        junk_ok = 1'b1; waited = 0;
        while (!done && waited < 1000) begin
            in_valid = 1'b1; in_re = 16'(nextr(30000)); in_im = 16'(-nextr(30000));
            if (in_ready) junk_ok = 1'b0;
            @(posedge clk); #1;
            waited++;
        end
        chk(junk_ok, "R9 in_ready low while computing", int'(junk_ok), 1);
        chk(cyc - acc == RUNC, "R5 done latency", cyc - acc, RUNC);
        chk(int'(busy_cycles) == RUNC, "R6 busy_cycles", int'(busy_cycles), RUNC);
        // readout with stalls (R3, R4, R7, R8)
        idx = 0; stalled = 1'b0; pre = 0; pim = 0; waited = 0;
        while (idx < N && waited < 1000) begin
            out_ready = ((cyc + pat) % 3) != 0;
            in_valid = 1'b1; in_re = 16'(nextr(30000));
            if (stalled) begin
                chk(out_valid && int'(out_re) == pre, "R7 stall holds re", int'(out_re), pre);
                chk(int'(out_im) == pim, "R7 stall holds im", int'(out_im), pim);
            end
            chk(in_ready == 1'b0, "R9 in_ready low in readout", int'(in_ready), 0);
            if (out_valid && out_ready) begin
                chk(int'(out_re) == er[idx], {tag, " real word"}, int'(out_re), er[idx]);
                chk(int'(out_im) == ei[idx], {tag, " imag word"}, int'(out_im), ei[idx]);
                chk(out_last == (idx == N - 1), "R8 out_last position", int'(out_last), int'(idx == N - 1));
                if (pat == 1)
                    chk(int'(out_re) == ((idx == 1) ? N * 300 : 0), "R4 bin order", int'(out_re), (idx == 1) ? N * 300 : 0);
                idx++;
                stalled = 1'b0;
            end else begin
                stalled = out_valid;
                pre = int'(out_re); pim = int'(out_im);
            end
            @(posedge clk); #1;
            waited++;
        end
        out_ready = 1'b0; in_valid = 1'b0;
        chk(idx == N, "R7 all words delivered", idx, N);
        chk(in_ready && !done, "R8 return to load", int'(in_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        for (int p = 0; p < 7; p++) do_frame(p);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule